// File: doc/BRIEF.md
# Playback Sample Tick and DAC Word Formatter

This block sets the pace of audio playback. A phase accumulator, stepped once per system clock by an amount proportional to an 8-bit rate value, produces a sample tick. The tick frequency is the rate value times 46615120/262144 Hz, about 177.8 Hz per unit of rate. A rate of zero gives no ticks. The tick runs while at least one of the two DMA channels (byte-wide and word-wide) is running. It stops only when both channels are halted.

On each tick the block takes the 32-bit entry at the playback FIFO tail and converts it into a left and a right 16-bit signed DAC word. The mode byte decides the conversion: sample width, signedness and mono or stereo. The block then asks each running DMA channel for more data and advances the FIFO tail.

In per-sample interrupt mode a tick does none of that. It only signals the controller, and only when the byte channel is running. The capture path and the analog converter are outside this block.

Top module: `pcm_dac_tick`

## Requirements
- R1: A tick occurs on each clock where the accumulator plus `rate*UNIT_STEP` reaches 2^ACC_W. The accumulator keeps the sum modulo 2^ACC_W and is cleared whenever the tick is not allowed to run. So after enabling, the first tick comes ceil(2^ACC_W/step) clocks later. A rate of zero produces no tick.
- R2: Ticks are allowed only while `ch8_halt` or `ch16_halt` is low. With both high, nothing is output.
- R3: With `mode[0]`=1 the samples are 16-bit. The left sample is `fifo_word[15:0]` and the right sample is `fifo_word[31:16]`. With `mode[5]`=1 each half is passed unchanged. With `mode[5]`=0, 0x8000 is subtracted modulo 2^16.
- R4: With `mode[0]`=0 the samples are 8-bit. The left sample is `fifo_word[7:0]` and the right sample is `fifo_word[23:16]`. With `mode[4]`=1 the byte is placed in the upper 8 bits over zeros. With `mode[4]`=0, 0x80 is subtracted from the byte first.
- R5: In mono mode both outputs carry the left sample. Mono is selected by `mode[7]` for 16-bit samples and by `mode[6]` for 8-bit samples. The signedness and mono bits of the width not selected have no effect.
- R6: The block updates `dac_left` and `dac_right` together on the clock edge where the tick occurs, and `dac_valid` is high for exactly that one following cycle. Between ticks the outputs hold their values.
- R7: With `mode[1]`=1, a tick pulses `ctrl_irq` for one cycle if `ch8_halt` is low. In this mode the tick changes no DAC output, no DMA request and no tail pointer. With `ch8_halt` high it does nothing at all.
- R8: On a formatting tick, `drq8_req` pulses if `ch8_halt` is low and `drq16_req` pulses if `ch16_halt` is low. Both pulses fall in the same cycle as `dac_valid`.
- R9: On a formatting tick, `fifo_tail` advances by one modulo FIFO_DEPTH if the channel feeding the DAC is running. That channel is the word channel when `mode[0]`=1 and the byte channel otherwise. Outside such a tick the tail never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate | input | 8 | Sample rate value, 0 stops the tick |
| mode | input | 8 | Format and interrupt mode byte |
| ch8_halt | input | 1 | Byte-wide DMA channel stopped |
| ch16_halt | input | 1 | Word-wide DMA channel stopped |
| fifo_word | input | 32 | Playback FIFO entry at the current tail |
| fifo_tail | output | 4 | Playback FIFO tail pointer |
| dac_left | output | 16 | Left DAC word |
| dac_right | output | 16 | Right DAC word |
| dac_valid | output | 1 | One-cycle strobe on a DAC update |
| drq8_req | output | 1 | Byte channel DMA re-request pulse |
| drq16_req | output | 1 | Word channel DMA re-request pulse |
| ctrl_irq | output | 1 | Per-sample controller interrupt pulse |

## Verification
All eight format cases run on a single FIFO word. That word has different upper and lower halves, a byte 0 of exactly 0x80 and a byte 2 above 0x80, so a swapped half, a wrong byte lane, an inverted sign rule or a missing shift each produce a different output. One 16-bit case also has the 8-bit signedness and mono bits set, which shows that the bits of the other width are ignored.

The channel halt inputs are tried in all three combinations that matter:
- Both running, where the tick and both requests are present.
- Only the word channel running, which keeps the tick alive but must not move the tail in 8-bit mode.
- Both halted, where the tick must stop.

Two rate values confirm that the tick interval scales inversely with the rate. A sixteen-tick run shows the tail pointer wrapping.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

  localparam int SAMPLE_W = 16;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * SAMPLE_W;

  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef struct packed {
    sample_t right;
    sample_t left;
  } dac_pair_t;

  // unsigned 16-bit: remove the mid-scale offset
  function automatic sample_t wide_to_dac(input sample_t raw, input logic is_signed);
    sample_t offs;
    offs = {1'b1, {(SAMPLE_W-1){1'b0}}};
    return is_signed ? raw : sample_t'(raw - offs);
  endfunction

  // 8-bit: recentre when unsigned, then move into the upper byte
  function automatic sample_t narrow_to_dac(input logic [BYTE_W-1:0] raw, input logic is_signed);
    logic [BYTE_W-1:0] cen;
    cen = is_signed ? raw : BYTE_W'(raw - {1'b1, {(BYTE_W-1){1'b0}}});
    return {cen, {(SAMPLE_W-BYTE_W){1'b0}}};
  endfunction

endpackage

// File: rtl/pcm_rate_accum.sv
module pcm_rate_accum #(
  parameter int RATE_W    = 8,
  parameter int ACC_W     = 24,
  parameter int UNIT_STEP = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] step;
  logic [SUM_W-1:0] sum;

  always_comb begin
    step = SUM_W'(rate) * SUM_W'(UNIT_STEP);
    sum  = {1'b0, acc_q} + step;
    tick = run && sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (!run)   acc_q <= '0;
    else             acc_q <= sum[ACC_W-1:0];
  end

  // R1: a cleared accumulator cannot carry on the very next add
  p_clear_then_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> !(tick && ($past(rate) == rate) && (SUM_W'(rate) * SUM_W'(UNIT_STEP) < (SUM_W'(1) << ACC_W))));

endmodule

// File: rtl/pcm_sample_fmt.sv
module pcm_sample_fmt
  import pcm_fmt_pkg::*;
(
  input  logic [7:0]        mode,
  input  logic [WORD_W-1:0] word,
  output dac_pair_t         pair
);
  logic    wide, sgn, mono;
  sample_t first, second;

  always_comb begin
    wide = mode[0];
    sgn  = wide ? mode[5] : mode[4];
    mono = wide ? mode[7] : mode[6];
    if (wide) begin
      first  = wide_to_dac(word[SAMPLE_W-1:0], sgn);
      second = wide_to_dac(word[WORD_W-1:SAMPLE_W], sgn);
    end else begin
      first  = narrow_to_dac(word[BYTE_W-1:0], sgn);
      second = narrow_to_dac(word[SAMPLE_W+BYTE_W-1:SAMPLE_W], sgn);
    end
    pair.left  = first;
    pair.right = mono ? first : second;
  end

endmodule

// File: rtl/pcm_tick_action.sv
module pcm_tick_action
  import pcm_fmt_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [7:0]                    mode,
  input  logic                          ch8_halt,
  input  logic                          ch16_halt,
  input  dac_pair_t                     pair,
  output logic [$clog2(FIFO_DEPTH)-1:0] tail,
  output sample_t                       left,
  output sample_t                       right,
  output logic                          valid,
  output logic                          drq8,
  output logic                          drq16,
  output logic                          irq
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic per_sample, feed_running, fmt_tick;

  always_comb begin
    per_sample   = mode[1];
    feed_running = mode[0] ? !ch16_halt : !ch8_halt;
    fmt_tick     = tick && !per_sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail  <= '0;
      left  <= '0;
      right <= '0;
      valid <= 1'b0;
      drq8  <= 1'b0;
      drq16 <= 1'b0;
      irq   <= 1'b0;
    end else begin
      valid <= fmt_tick;
      drq8  <= fmt_tick && !ch8_halt;
      drq16 <= fmt_tick && !ch16_halt;
      irq   <= tick && per_sample && !ch8_halt;
      if (fmt_tick) begin
        left  <= pair.left;
        right <= pair.right;
        if (feed_running) tail <= PTR_W'(tail + 1'b1);
      end
    end
  end

  p_irq_needs_byte_ch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!$past(ch8_halt) && $past(mode[1]) && !valid));

  p_drq8_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drq8 |-> (valid && !$past(ch8_halt)));

  p_drq16_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drq16 |-> (valid && !$past(ch16_halt)));

  p_tail_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tail != $past(tail)) |-> (valid && tail == PTR_W'($past(tail) + 1'b1)));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(left) && $stable(right)));

endmodule

// File: rtl/pcm_dac_tick.sv
module pcm_dac_tick
  import pcm_fmt_pkg::*;
#(
  parameter int RATE_W     = 8,
  parameter int ACC_W      = 24,
  parameter int UNIT_STEP  = 30,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic [7:0]        mode,
  input  logic              ch8_halt,
  input  logic              ch16_halt,
  input  logic [31:0]       fifo_word,
  output logic [3:0]        fifo_tail,
  output logic [15:0]       dac_left,
  output logic [15:0]       dac_right,
  output logic              dac_valid,
  output logic              drq8_req,
  output logic              drq16_req,
  output logic              ctrl_irq
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic             run_en;
  logic             tick_evt;
  dac_pair_t        fmt_pair;
  logic [PTR_W-1:0] tail_ptr;

  assign run_en = (rate != '0) && !(ch8_halt && ch16_halt);

  pcm_rate_accum #(
    .RATE_W(RATE_W), .ACC_W(ACC_W), .UNIT_STEP(UNIT_STEP)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .run(run_en), .rate(rate), .tick(tick_evt)
  );

  pcm_sample_fmt u_fmt (
    .mode(mode), .word(fifo_word), .pair(fmt_pair)
  );

  pcm_tick_action #(.FIFO_DEPTH(FIFO_DEPTH)) u_act (
    .clk(clk), .rst_n(rst_n), .tick(tick_evt), .mode(mode),
    .ch8_halt(ch8_halt), .ch16_halt(ch16_halt), .pair(fmt_pair),
    .tail(tail_ptr), .left(dac_left), .right(dac_right), .valid(dac_valid),
    .drq8(drq8_req), .drq16(drq16_req), .irq(ctrl_irq)
  );

  assign fifo_tail = 4'(tail_ptr);

  p_rate_zero_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |=> !(dac_valid || ctrl_irq));

  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch8_halt && ch16_halt) |=> !(dac_valid || ctrl_irq));

  p_mono_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && ($past(mode[0]) ? $past(mode[7]) : $past(mode[6]))) |-> (dac_left == dac_right));

endmodule

// File: tb/pcm_dac_tick_bench.sv
module pcm_dac_tick_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rate = '0;
  logic [7:0]  mode = '0;
  logic        ch8_halt = 1'b1;
  logic        ch16_halt = 1'b1;
  logic [31:0] fifo_word = 32'hC3A5_1F80;
  logic [3:0]  fifo_tail;
  logic [15:0] dac_left, dac_right;
  logic        dac_valid, drq8_req, drq16_req, ctrl_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // step = rate, tick when accumulated value reaches 256
  pcm_dac_tick #(.ACC_W(8), .UNIT_STEP(1)) u_pcm_dac_tick (
    .clk(clk), .rst_n(rst_n), .rate(rate), .mode(mode),
    .ch8_halt(ch8_halt), .ch16_halt(ch16_halt), .fifo_word(fifo_word),
    .fifo_tail(fifo_tail), .dac_left(dac_left), .dac_right(dac_right),
    .dac_valid(dac_valid), .drq8_req(drq8_req), .drq16_req(drq16_req),
    .ctrl_irq(ctrl_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {right,left} from the requirement text
  function automatic logic [31:0] expect_pair(input logic [7:0] m, input logic [31:0] w);
    logic [15:0] a, b;
    logic [7:0]  x, y;
    if (m[0]) begin
      a = w[15:0];
      b = m[7] ? w[15:0] : w[31:16];
      if (!m[5]) begin a = a + 16'h8000; b = b + 16'h8000; end
    end else begin
      x = w[7:0];
      y = m[6] ? w[7:0] : w[23:16];
      if (!m[4]) begin x = x - 8'h80; y = y - 8'h80; end
      a = 16'(x) << 8;
      b = 16'(y) << 8;
    end
    return {b, a};
  endfunction

  task automatic step_clk;
    @(posedge clk); #1;
  endtask

  // restart the accumulator from zero with the new settings
  task automatic setup(input logic [7:0] r, input logic [7:0] m, input logic h8, input logic h16);
    rate = 8'd0; step_clk;
    mode = m; ch8_halt = h8; ch16_halt = h16; rate = r;
  endtask

  task automatic wait_event(input int max_cyc, output int n);
    n = 0;
    for (int i = 1; i <= max_cyc; i++) begin
      step_clk;
      if (dac_valid || ctrl_irq) begin n = i; return; end
    end
  endtask

  task automatic t_reset;
    check("R6 reset valid", 32'(dac_valid), 32'd0);
    check("R6 reset left/right", {dac_right, dac_left}, 32'd0);
    check("R9 reset tail", 32'(fifo_tail), 32'd0);
    check("R7 reset irq", 32'(ctrl_irq), 32'd0);
  endtask

  task automatic t_rate;
    int n;
    setup(8'd0, 8'h00, 1'b0, 1'b0);
    wait_event(60, n);
    check("R1 zero rate gives no tick", 32'(n), 32'd0);
    setup(8'd64, 8'h00, 1'b0, 1'b0);
    wait_event(20, n);
    check("R1 first tick at rate 64", 32'(n), 32'd4);
    wait_event(20, n);
    check("R1 period at rate 64", 32'(n), 32'd4);
    setup(8'd32, 8'h00, 1'b0, 1'b0);
    wait_event(20, n);
    check("R1 first tick at rate 32", 32'(n), 32'd8);
  endtask

  task automatic t_halt;
    int n;
    setup(8'd64, 8'h01, 1'b1, 1'b1);
    wait_event(40, n);
    check("R2 both halted, no tick", 32'(n), 32'd0);
    setup(8'd64, 8'h01, 1'b1, 1'b0);
    wait_event(20, n);
    check("R2 word channel keeps tick", 32'(n), 32'd4);
  endtask

  task automatic t_formats;
    logic [7:0] modes [9];
    int n;
    modes = '{8'h01, 8'h21, 8'h81, 8'hA1, 8'h00, 8'h10, 8'h40, 8'h50, 8'h51};
    foreach (modes[k]) begin
      setup(8'd64, modes[k], 1'b0, 1'b0);
      wait_event(20, n);
      if (modes[k][0])
        check($sformatf("R3 R5 16-bit format mode %h", modes[k]),
              {dac_right, dac_left}, expect_pair(modes[k], fifo_word));
      else
        check($sformatf("R4 R5 8-bit format mode %h", modes[k]),
              {dac_right, dac_left}, expect_pair(modes[k], fifo_word));
    end
  endtask

  task automatic t_strobe;
    int n;
    logic [31:0] held;
    setup(8'd64, 8'h21, 1'b0, 1'b0);
    wait_event(20, n);
    held = {dac_right, dac_left};
    check("R8 both requests on tick", {30'd0, drq16_req, drq8_req}, 32'd3);
    fifo_word = 32'h1234_5678;
    step_clk;
    check("R6 strobe one cycle", 32'(dac_valid), 32'd0);
    check("R6 outputs hold", {dac_right, dac_left}, held);
    wait_event(20, n);
    check("R6 next tick takes new word", {dac_right, dac_left}, 32'h1234_5678);
    fifo_word = 32'hC3A5_1F80;
  endtask

  task automatic t_irq;
    int n;
    logic [3:0]  t0;
    logic [31:0] held;
    held = {dac_right, dac_left};
    t0 = fifo_tail;
    setup(8'd64, 8'h02, 1'b0, 1'b1);
    wait_event(20, n);
    check("R7 irq on tick", {29'd0, ctrl_irq, dac_valid, drq8_req}, 32'd4);
    check("R7 irq leaves tail", 32'(fifo_tail), 32'(t0));
    check("R7 irq leaves DAC", {dac_right, dac_left}, held);
    setup(8'd64, 8'h02, 1'b1, 1'b0);
    wait_event(20, n);
    check("R7 byte channel halted, no irq", 32'(n), 32'd0);
    check("R7 halted irq mode leaves tail", 32'(fifo_tail), 32'(t0));
  endtask

  task automatic t_tail;
    int n;
    int bad;
    logic [3:0] t0, exp_t;
    // 8-bit mode, byte channel running
    setup(8'd64, 8'h00, 1'b0, 1'b1);
    t0 = fifo_tail; bad = 0; exp_t = t0;
    for (int k = 0; k < 16; k++) begin
      wait_event(20, n);
      exp_t = exp_t + 4'd1;
      if (fifo_tail !== exp_t || !drq8_req || drq16_req) bad++;
    end
    check("R9 tail steps and wraps", 32'(fifo_tail), 32'(t0));
    check("R8 R9 per-tick step/request errors", 32'(bad), 32'd0);
    // 16-bit mode fed by halted word channel: tick but no tail move
    setup(8'd64, 8'h01, 1'b0, 1'b1);
    t0 = fifo_tail;
    wait_event(20, n);
    check("R9 halted feeder, tick seen", 32'(dac_valid), 32'd1);
    check("R9 halted feeder, tail kept", 32'(fifo_tail), 32'(t0));
    check("R8 only byte request", {30'd0, drq16_req, drq8_req}, 32'd1);
    // 8-bit mode with only the word channel running
    setup(8'd64, 8'h00, 1'b1, 1'b0);
    t0 = fifo_tail;
    wait_event(20, n);
    check("R9 8-bit feeder halted, tail kept", 32'(fifo_tail), 32'(t0));
    check("R8 only word request", {30'd0, drq16_req, drq8_req}, 32'd2);
  endtask

  initial begin
    repeat (3) step_clk;
    rst_n = 1'b1;
    step_clk;
    t_reset;
    t_rate;
    t_halt;
    t_formats;
    t_strobe;
    t_irq;
    t_tail;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule